// File: doc/BRIEF.md
# Set/Clear Interrupt Mask Unit

This block gathers completion events from a number of transmit channels and a number of receive channels, plus one host-error event, into three raw status groups. Each group has its own mask. Software never writes a mask directly. It writes ones to a set register to enable sources and ones to a clear register to disable them, so two agents can change different bits without a read-modify-write race. The masked status of each group is the raw status ANDed with that group's mask.

The combined interrupt line gives a single-cycle pulse when any masked source is pending and the output is armed. After the pulse the line stays low until software writes the end-of-interrupt register. If a masked source is still pending at that point, a fresh pulse follows. A read-only vector register tells the handler which groups have masked sources pending.

Register access uses a plain synchronous write strobe with a byte address, and reads are combinational. The event inputs are levels that their sources hold until they are acknowledged elsewhere. The block samples them into the raw registers every cycle.

Top module: `imask_unit`

## Requirements
- R1: After reset all raw status and all mask bits read as 0 and the interrupt line is 0.
- R2: One clock edge after the event inputs change, bit i of the transmit raw register (address 0x80) equals tx_evt[i] and bit i of the receive raw register (address 0xA0) equals rx_evt[i]. Unused upper bits read 0.
- R3: The host-error event appears at bit 1 of the error raw register (address 0xB0), and every other bit of that register reads 0.
- R4: Writing to a set register (transmit 0x88, receive 0xA8, error 0xB8) sets the mask bits where the data has ones and leaves the bits where it has zeros. Reading the set or clear address of a group returns that group's mask.
- R5: Writing to a clear register (transmit 0x8C, receive 0xAC, error 0xBC) clears the mask bits where the data has ones and leaves the other bits. Writing all ones disables every source in the group.
- R6: The masked status registers (0x84, 0xA4, 0xB4) read as the raw status ANDed with the group's mask.
- R7: When the output is armed and any masked bit is set, the interrupt line goes high one clock edge later for exactly one cycle.
- R8: After a pulse the interrupt line stays low, whatever is pending, until a write to the end-of-interrupt address 0x94 (any data). A masked source still pending at that write produces a new pulse one edge after the write's edge.
- R9: The vector register at 0x90 reads bit 0 = any transmit masked bit, bit 1 = any receive masked bit, bit 2 = host-error masked bit, and all other bits 0.
- R10: Writes to the raw, masked and vector addresses change no state. Sources with their mask bit at 0 never raise the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tx_evt | input | NUM_CH | Transmit channel event levels |
| rx_evt | input | NUM_CH | Receive channel event levels |
| host_err | input | 1 | Host-error event level |
| irq | output | 1 | Combined interrupt pulse |

## Verification
A corrupted mask bit shows up in the same cycle on the set, clear and masked read addresses. It also shows up one edge later as a missing or unexpected pulse on irq. A wrong arm state shows as a second pulse with no end-of-interrupt write, or as a missing pulse one edge after such a write, so every test runs the pending, pulse, blocked and re-arm cycle with exact cycle sampling. Set and clear writes use data patterns that mix ones and zeros, so a mask that is overwritten instead of merged reads back wrong at once.

// File: rtl/imask_pkg.sv
package imask_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int HOST_ERR_BIT = 1;

  localparam logic [ADDR_W-1:0] A_TX_RAW  = 8'h80;
  localparam logic [ADDR_W-1:0] A_TX_MSK  = 8'h84;
  localparam logic [ADDR_W-1:0] A_TX_SET  = 8'h88;
  localparam logic [ADDR_W-1:0] A_TX_CLR  = 8'h8C;
  localparam logic [ADDR_W-1:0] A_VECTOR  = 8'h90;
  localparam logic [ADDR_W-1:0] A_EOI     = 8'h94;
  localparam logic [ADDR_W-1:0] A_RX_RAW  = 8'hA0;
  localparam logic [ADDR_W-1:0] A_RX_MSK  = 8'hA4;
  localparam logic [ADDR_W-1:0] A_RX_SET  = 8'hA8;
  localparam logic [ADDR_W-1:0] A_RX_CLR  = 8'hAC;
  localparam logic [ADDR_W-1:0] A_ER_RAW  = 8'hB0;
  localparam logic [ADDR_W-1:0] A_ER_MSK  = 8'hB4;
  localparam logic [ADDR_W-1:0] A_ER_SET  = 8'hB8;
  localparam logic [ADDR_W-1:0] A_ER_CLR  = 8'hBC;

  typedef enum logic [1:0] {
    GRP_TX  = 2'd0,
    GRP_RX  = 2'd1,
    GRP_ERR = 2'd2
  } grp_e;

  localparam int NUM_GRP = 3;
endpackage

// File: rtl/imask_group.sv
module imask_group #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] raw_o,
  output logic [WIDTH-1:0] mask_o,
  output logic [WIDTH-1:0] masked_o,
  output logic             pend_o
);
  logic [WIDTH-1:0] raw_q, raw_d;
  logic [WIDTH-1:0] mask_q, mask_d;
  logic             mask_en;

  assign mask_en = set_we | clr_we;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      always_comb begin
        raw_d[b]  = evt[b];
        mask_d[b] = mask_q[b];
        if (set_we && wdata[b]) mask_d[b] = 1'b1;
        if (clr_we && wdata[b]) mask_d[b] = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          raw_q[b] <= 1'b0;
        end else begin
          raw_q[b] <= raw_d[b];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mask_q[b] <= 1'b0;
        end else if (mask_en) begin
          mask_q[b] <= mask_d[b];
        end
      end
    end
  endgenerate

  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
  assign masked_o = raw_q & mask_q;
  assign pend_o   = |(raw_q & mask_q);
endmodule

// File: rtl/imask_rearm.sv
module imask_rearm (
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend,
  input  logic eoi_wr,
  output logic irq
);
  logic armed_q, armed_d;
  logic irq_q, irq_d;

  always_comb begin
    irq_d   = armed_q & any_pend;
    armed_d = armed_q & ~any_pend;
    if (eoi_wr) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      irq_q   <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/imask_unit.sv
module imask_unit
  import imask_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] tx_evt,
  input  logic [NUM_CH-1:0] rx_evt,
  input  logic              host_err,
  output logic              irq
);
  logic [NUM_CH-1:0] tx_raw, tx_mask, tx_masked;
  logic [NUM_CH-1:0] rx_raw, rx_mask, rx_masked;
  logic [0:0]        er_raw, er_mask, er_masked;
  logic [NUM_GRP-1:0] grp_pend;
  logic              any_pend;
  logic              eoi_wr;

  imask_group #(.WIDTH(NUM_CH)) u_tx (
    .clk(clk), .rst_n(rst_n), .evt(tx_evt),
    .set_we(bus_we && bus_addr == A_TX_SET),
    .clr_we(bus_we && bus_addr == A_TX_CLR),
    .wdata(bus_wdata[NUM_CH-1:0]),
    .raw_o(tx_raw), .mask_o(tx_mask), .masked_o(tx_masked),
    .pend_o(grp_pend[GRP_TX])
  );

  imask_group #(.WIDTH(NUM_CH)) u_rx (
    .clk(clk), .rst_n(rst_n), .evt(rx_evt),
    .set_we(bus_we && bus_addr == A_RX_SET),
    .clr_we(bus_we && bus_addr == A_RX_CLR),
    .wdata(bus_wdata[NUM_CH-1:0]),
    .raw_o(rx_raw), .mask_o(rx_mask), .masked_o(rx_masked),
    .pend_o(grp_pend[GRP_RX])
  );

  imask_group #(.WIDTH(1)) u_er (
    .clk(clk), .rst_n(rst_n), .evt(host_err),
    .set_we(bus_we && bus_addr == A_ER_SET),
    .clr_we(bus_we && bus_addr == A_ER_CLR),
    .wdata(bus_wdata[HOST_ERR_BIT]),
    .raw_o(er_raw), .mask_o(er_mask), .masked_o(er_masked),
    .pend_o(grp_pend[GRP_ERR])
  );

  assign any_pend = |grp_pend;
  assign eoi_wr   = bus_we && (bus_addr == A_EOI);

  imask_rearm u_arm (
    .clk(clk), .rst_n(rst_n), .any_pend(any_pend),
    .eoi_wr(eoi_wr), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_TX_RAW:           bus_rdata = DATA_W'(tx_raw);
      A_TX_MSK:           bus_rdata = DATA_W'(tx_masked);
      A_TX_SET, A_TX_CLR: bus_rdata = DATA_W'(tx_mask);
      A_RX_RAW:           bus_rdata = DATA_W'(rx_raw);
      A_RX_MSK:           bus_rdata = DATA_W'(rx_masked);
      A_RX_SET, A_RX_CLR: bus_rdata = DATA_W'(rx_mask);
      A_ER_RAW:           bus_rdata = DATA_W'(er_raw) << HOST_ERR_BIT;
      A_ER_MSK:           bus_rdata = DATA_W'(er_masked) << HOST_ERR_BIT;
      A_ER_SET, A_ER_CLR: bus_rdata = DATA_W'(er_mask) << HOST_ERR_BIT;
      A_VECTOR:           bus_rdata = DATA_W'(grp_pend);
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/imask_checks.sv
module imask_checks
  import imask_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq,
  input logic [NUM_CH-1:0] tx_mask,
  input logic [NUM_CH-1:0] rx_mask,
  input logic [0:0]        er_mask,
  input logic              any_pend
);
  logic blocked_q;
  logic eoi_seen;
  logic tx_touch, rx_touch, er_touch;

  assign eoi_seen = bus_we && bus_addr == A_EOI;
  assign tx_touch = bus_we && (bus_addr == A_TX_SET || bus_addr == A_TX_CLR);
  assign rx_touch = bus_we && (bus_addr == A_RX_SET || bus_addr == A_RX_CLR);
  assign er_touch = bus_we && (bus_addr == A_ER_SET || bus_addr == A_ER_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked_q <= 1'b0;
    end else if (eoi_seen) begin
      blocked_q <= 1'b0;
    end else if (irq) begin
      blocked_q <= 1'b1;
    end
  end

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_pend));

  a_r8_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_q |-> !irq);

  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_TX_CLR && bus_wdata == '1) |=> (tx_mask == '0));

  a_r10_mask_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_touch || rx_touch || er_touch) |=>
      ($stable(tx_mask) && $stable(rx_mask) && $stable(er_mask)));
endmodule

bind imask_unit imask_checks #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq(irq), .tx_mask(tx_mask), .rx_mask(rx_mask),
  .er_mask(er_mask), .any_pend(any_pend)
);

// File: tb/sim_imask_unit.sv
module sim_imask_unit;
  localparam int PERIOD = 10;
  localparam int NCH = 8;

  logic            clk;
  logic            rst_n;
  logic            bus_we;
  logic [7:0]      bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [NCH-1:0]  tx_evt;
  logic [NCH-1:0]  rx_evt;
  logic            host_err;
  logic            irq;

  int n_chk;
  int n_bad;

  imask_unit #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .host_err(host_err), .irq(irq)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
    bus_addr = 8'h00;
  endtask

  task automatic quiet_all();
    tx_evt = '0; rx_evt = '0; host_err = 1'b0;
    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'hAC, 32'hFFFF_FFFF);
    wr(8'hBC, 32'hFFFF_FFFF);
    wr(8'h94, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk("R1 tx raw", 8'h80, 0);
    rd_chk("R1 tx mask", 8'h88, 0);
    rd_chk("R1 rx mask", 8'hA8, 0);
    rd_chk("R1 err mask", 8'hB8, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_raw();
    tx_evt = 8'hA5; rx_evt = 8'h3C; host_err = 1'b1;
    rd_chk("R2 raw before edge", 8'h80, 0);
    @(negedge clk);
    rd_chk("R2 tx raw", 8'h80, 32'hA5);
    rd_chk("R2 rx raw", 8'hA0, 32'h3C);
    rd_chk("R3 err raw bit1", 8'hB0, 32'h2);
    repeat (3) @(negedge clk);
    check("R10 unmasked no irq", {31'b0, irq}, 0);
    tx_evt = 8'h5A;
    @(negedge clk);
    rd_chk("R2 tx raw follows", 8'h80, 32'h5A);
    quiet_all();
  endtask

  task automatic t_set_clear();
    wr(8'h88, 32'h0F);
    rd_chk("R4 set", 8'h88, 32'h0F);
    wr(8'h88, 32'h30);
    rd_chk("R4 zeros keep", 8'h88, 32'h3F);
    wr(8'h8C, 32'h05);
    rd_chk("R5 clear partial", 8'h8C, 32'h3A);
    wr(8'h8C, 32'hFFFF_FFFF);
    rd_chk("R5 clear all tx", 8'h88, 0);
    wr(8'hA8, 32'hFF);
    rd_chk("R4 rx set", 8'hAC, 32'hFF);
    wr(8'hAC, 32'hFFFF_FFFF);
    rd_chk("R5 clear all rx", 8'hA8, 0);
    wr(8'hB8, 32'hFFFF_FFFF);
    rd_chk("R4 err set bit1 only", 8'hB8, 32'h2);
    wr(8'hBC, 32'h2);
    rd_chk("R5 err clear", 8'hBC, 0);
    quiet_all();
  endtask

  task automatic t_masked();
    tx_evt = 8'hA5; rx_evt = 8'h3C; host_err = 1'b1;
    wr(8'h88, 32'h0F);
    wr(8'hA8, 32'hF0);
    rd_chk("R9 vector tx rx", 8'h90, 32'h3);
    wr(8'hB8, 32'h2);
    rd_chk("R6 tx masked", 8'h84, 32'h05);
    rd_chk("R6 rx masked", 8'hA4, 32'h30);
    rd_chk("R6 err masked", 8'hB4, 32'h2);
    rd_chk("R9 vector all", 8'h90, 32'h7);
    wr(8'h8C, 32'hFF);
    wr(8'hAC, 32'hFF);
    rd_chk("R9 vector err only", 8'h90, 32'h4);
    quiet_all();
  endtask

  task automatic t_irq();
    rx_evt = 8'h04;
    @(negedge clk);
    check("R10 masked off", {31'b0, irq}, 0);
    wr(8'hA8, 32'h04);
    check("R7 not yet", {31'b0, irq}, 0);
    @(negedge clk);
    check("R7 pulse", {31'b0, irq}, 1);
    @(negedge clk);
    check("R7 one cycle", {31'b0, irq}, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R8 held low", {31'b0, irq}, 0);
    end
    wr(8'h94, 32'h0);
    check("R8 not yet", {31'b0, irq}, 0);
    @(negedge clk);
    check("R8 repulse", {31'b0, irq}, 1);
    @(negedge clk);
    check("R8 one cycle", {31'b0, irq}, 0);
    quiet_all();
    check("R8 no pulse idle eoi", {31'b0, irq}, 0);
    host_err = 1'b1;
    wr(8'hB8, 32'h2);
    @(negedge clk);
    check("R7 host err pulse", {31'b0, irq}, 1);
    quiet_all();
  endtask

  task automatic t_ro();
    tx_evt = 8'h11;
    wr(8'h80, 32'hFF);
    wr(8'h84, 32'hFF);
    wr(8'h90, 32'hFF);
    wr(8'hA0, 32'hFF);
    wr(8'hB4, 32'hFF);
    rd_chk("R10 tx mask kept", 8'h88, 0);
    rd_chk("R10 rx mask kept", 8'hA8, 0);
    rd_chk("R10 err mask kept", 8'hB8, 0);
    rd_chk("R10 raw kept", 8'h80, 32'h11);
    check("R10 no irq", {31'b0, irq}, 0);
    quiet_all();
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    tx_evt = '0; rx_evt = '0; host_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw();
    t_set_clear();
    t_masked();
    t_irq();
    t_ro();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule